// File: doc/BRIEF.md
# Floating-Point Sign-Injection and Flags Unit

This unit performs the three sign-injection operations on floating-point values held in wide registers: plain copy of a sign, negated copy, and exclusive-or of two signs. It handles single and double precision. A narrow value sits in the low bits of the wide register. Its upper bits must all be ones, or the operand is replaced by the canonical quiet NaN of that precision. Every result it writes back has all bits above its precision set to one.

The same unit also resolves the instruction's rounding-mode field against a dynamic rounding-mode register that has its own write port, and flags illegal encodings. It keeps the sticky five-bit accrued-exception register fed by an external arithmetic unit, and the floating-point dirty indication. An operation strobed on `op_valid` produces a registered result one cycle later, marked by `res_valid`.

Top module: `fsgn_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the accrued flags, the dynamic rounding mode (so rm field 7 then resolves to 0), the dirty indication and `res_valid`.
- R2: With `op_sel` = 0, the result sign is the sign of operand b and all other bits of the value come from operand a. The result appears with `res_valid` high in the cycle after `op_valid`.
- R3: With `op_sel` = 1, the result sign is the inverse of operand b's sign. The magnitude comes from operand a.
- R4: With `op_sel` = 2, the result sign is sign(a) XOR sign(b). The magnitude comes from operand a.
- R5: With `is_double` = 0, an operand is a valid single only if bits REG_W-1..32 are all ones. Otherwise it is treated as 0x7FC00000. The result has every bit above bit 31 set to one.
- R6: With `is_double` = 1, an operand is a valid double only if bits REG_W-1..64 are all ones. Otherwise it is treated as 0x7FF8000000000000. The result has every bit above bit 63 set to one.
- R7: Rounding-mode fields 0 to 4 (0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest with ties to max magnitude) are reported unchanged on `res_rm`. Field 7 reports the dynamic mode, which is loaded by `frm_we`. An operation in the same cycle as a write sees the old value.
- R8: Field values 5 or 6, field 7 with a dynamic mode above 4, or `op_sel` = 3 each give `res_illegal` = 1 with `res_data` all zero. `res_rm` still shows the resolved mode. Such an operation does not set the dirty indication.
- R9: On `exc_valid`, `exc_flags` (bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid) are ORed into `fflags` one cycle later. No bit is cleared except by reset.
- R10: `exc_valid` with any nonzero flag sets `fs_dirty`. `exc_valid` with all-zero flags leaves `fs_dirty` unchanged.
- R11: Every legal operation (a register write) sets `fs_dirty`. `fs_dirty` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 0 plain, 1 negated, 2 xor, 3 reserved |
| is_double | input | 1 | 1 selects double precision |
| rm_field | input | 3 | Instruction rounding-mode field |
| opnd_a | input | REG_W | Operand supplying the magnitude |
| opnd_b | input | REG_W | Operand supplying the sign |
| frm_we | input | 1 | Dynamic rounding-mode write enable |
| frm_wdata | input | 3 | Dynamic rounding-mode write value |
| exc_valid | input | 1 | Exception flags strobe |
| exc_flags | input | 5 | New exception flags |
| res_valid | output | 1 | Result valid, one cycle after op_valid |
| res_data | output | REG_W | Boxed result |
| res_rm | output | 3 | Resolved rounding mode |
| res_illegal | output | 1 | Illegal-instruction flag |
| fflags | output | 5 | Accrued exception flags |
| fs_dirty | output | 1 | Floating-point state dirty |

## Verification
The properties assume that reset is asserted from time zero and that `op_sel`, `rm_field` and the strobes are never unknown outside reset. They also assume REG_W is above 64, so the boxing region of a double exists. The stimulus changes every input only on the falling clock edge. It keeps all controls at defined values throughout, and it lets pending results drain before asserting reset a second time, so no result straddles a reset.

// File: rtl/fsgn_pkg.sv
package fsgn_pkg;

    localparam int SP_W  = 32;
    localparam int DP_W  = 64;
    localparam int EXC_W = 5;
    localparam int RM_W  = 3;

    localparam logic [SP_W-1:0] SP_QNAN = 32'h7FC0_0000;
    localparam logic [DP_W-1:0] DP_QNAN = 64'h7FF8_0000_0000_0000;

    localparam logic [RM_W-1:0] RM_LAST_LEGAL = 3'd4;
    localparam logic [RM_W-1:0] RM_FROM_REG   = 3'd7;

    typedef enum logic [1:0] {
        SGN_COPY = 2'd0,
        SGN_NEG  = 2'd1,
        SGN_XOR  = 2'd2,
        SGN_RSVD = 2'd3
    } sgn_op_e;

    typedef struct packed {
        logic [RM_W-1:0] mode;
        logic            bad;
    } rm_res_t;

    function automatic logic pick_sign(sgn_op_e op, logic sa, logic sb);
        case (op)
            SGN_COPY: return sb;
            SGN_NEG:  return ~sb;
            SGN_XOR:  return sa ^ sb;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fsgn_unbox.sv
module fsgn_unbox #(
    parameter int REG_W = 128,
    parameter int NW    = 32,
    parameter logic [NW-1:0] QNAN = '0
) (
    input  logic [REG_W-1:0] wide,
    output logic [NW-1:0]    narrow
);
    logic boxed_ok;

    assign boxed_ok = &wide[REG_W-1:NW];
    assign narrow   = boxed_ok ? wide[NW-1:0] : QNAN;
endmodule

// File: rtl/fsgn_inject.sv
module fsgn_inject
    import fsgn_pkg::*;
#(
    parameter int W = 32
) (
    input  sgn_op_e      op,
    input  logic [W-1:0] mag_src,
    input  logic [W-1:0] sgn_src,
    output logic [W-1:0] result
);
    logic sgn;

    always_comb begin
        sgn    = pick_sign(op, mag_src[W-1], sgn_src[W-1]);
        result = {sgn, mag_src[W-2:0]};
    end
endmodule

// File: rtl/fsgn_lane.sv
module fsgn_lane
    import fsgn_pkg::*;
#(
    parameter int REG_W = 128,
    parameter int W     = 32,
    parameter logic [W-1:0] QNAN = '0
) (
    input  sgn_op_e                op,
    input  logic [1:0][REG_W-1:0]  opnds,
    output logic [REG_W-1:0]       boxed
);
    localparam int PAD_W = REG_W - W;

    logic [1:0][W-1:0] val;
    logic [W-1:0]      inj;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        fsgn_unbox #(
            .REG_W (REG_W),
            .NW    (W),
            .QNAN  (QNAN)
        ) u_unbox (
            .wide   (opnds[g]),
            .narrow (val[g])
        );
    end

    fsgn_inject #(.W(W)) u_inject (
        .op      (op),
        .mag_src (val[0]),
        .sgn_src (val[1]),
        .result  (inj)
    );

    assign boxed = {{PAD_W{1'b1}}, inj};
endmodule

// File: rtl/fsgn_rm_resolve.sv
module fsgn_rm_resolve
    import fsgn_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic [RM_W-1:0] frm_cur,
    input  logic            op_rsvd,
    output rm_res_t         res
);
    always_comb begin
        res.mode = (rm_field == RM_FROM_REG) ? frm_cur : rm_field;
        res.bad  = (res.mode > RM_LAST_LEGAL) || op_rsvd;
    end
endmodule

// File: rtl/fsgn_flag_acc.sv
module fsgn_flag_acc
    import fsgn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_valid,
    input  logic [EXC_W-1:0] exc_flags,
    output logic [EXC_W-1:0] fflags,
    output logic             exc_raised
);
    assign exc_raised = exc_valid && (|exc_flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            fflags <= '0;
        end else if (exc_valid) begin
            fflags <= fflags | exc_flags;
        end
    end
endmodule

// File: rtl/fsgn_flag_unit.sv
module fsgn_flag_unit
    import fsgn_pkg::*;
#(
    parameter int REG_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic             is_double,
    input  logic [2:0]       rm_field,
    input  logic [REG_W-1:0] opnd_a,
    input  logic [REG_W-1:0] opnd_b,
    input  logic             frm_we,
    input  logic [2:0]       frm_wdata,
    input  logic             exc_valid,
    input  logic [4:0]       exc_flags,
    output logic             res_valid,
    output logic [REG_W-1:0] res_data,
    output logic [2:0]       res_rm,
    output logic             res_illegal,
    output logic [4:0]       fflags,
    output logic             fs_dirty
);
    sgn_op_e               op;
    logic [1:0][REG_W-1:0] opnds;
    logic [REG_W-1:0]      sp_boxed;
    logic [REG_W-1:0]      dp_boxed;
    logic [REG_W-1:0]      data_nxt;
    logic [RM_W-1:0]       frm_q;
    rm_res_t               rm_res;
    logic                  exc_raised;

    assign op    = sgn_op_e'(op_sel);
    assign opnds = {opnd_b, opnd_a};

    fsgn_lane #(.REG_W(REG_W), .W(SP_W), .QNAN(SP_QNAN)) u_sp_lane (
        .op    (op),
        .opnds (opnds),
        .boxed (sp_boxed)
    );

    fsgn_lane #(.REG_W(REG_W), .W(DP_W), .QNAN(DP_QNAN)) u_dp_lane (
        .op    (op),
        .opnds (opnds),
        .boxed (dp_boxed)
    );

    fsgn_rm_resolve u_rm (
        .rm_field (rm_field),
        .frm_cur  (frm_q),
        .op_rsvd  (op == SGN_RSVD),
        .res      (rm_res)
    );

    fsgn_flag_acc u_flags (
        .clk        (clk),
        .rst        (rst),
        .exc_valid  (exc_valid),
        .exc_flags  (exc_flags),
        .fflags     (fflags),
        .exc_raised (exc_raised)
    );

    always_comb begin
        if (rm_res.bad)     data_nxt = '0;
        else if (is_double) data_nxt = dp_boxed;
        else                data_nxt = sp_boxed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_rm      <= '0;
            res_illegal <= 1'b0;
            frm_q       <= '0;
            fs_dirty    <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_data    <= data_nxt;
                res_rm      <= rm_res.mode;
                res_illegal <= rm_res.bad;
            end
            if (frm_we) begin
                frm_q <= frm_wdata;
            end
            if (exc_raised || (op_valid && !rm_res.bad)) begin
                fs_dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsgn_flag_unit_chk.sv
module fsgn_flag_unit_chk #(
    parameter int REG_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [1:0]       op_sel,
    input logic [2:0]       rm_field,
    input logic             exc_valid,
    input logic [4:0]       exc_flags,
    input logic             res_valid,
    input logic [REG_W-1:0] res_data,
    input logic [2:0]       res_rm,
    input logic             res_illegal,
    input logic [4:0]       fflags,
    input logic             fs_dirty
);
    // R2
    res_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R5
    upper_box_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal) |-> (&res_data[REG_W-1:64]));

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_illegal) |-> (res_data == '0));

    // R7
    legal_rm_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal) |-> (res_rm <= 3'd4));

    // R8
    bad_field_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (rm_field == 3'd5 || rm_field == 3'd6 || op_sel == 2'd3)) |=> res_illegal);

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(fflags) & ~fflags) == 5'd0));

    // R9
    flags_accrue_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> ((fflags & $past(exc_flags)) == $past(exc_flags)));

    // R10
    exc_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && (exc_flags != 5'd0)) |=> fs_dirty);

    // R11
    dirty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$fell(fs_dirty));
endmodule

bind fsgn_flag_unit fsgn_flag_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/fsgn_flag_unit_tb.sv
module fsgn_flag_unit_tb;
    localparam int REG_W = 128;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             op_valid = 1'b0;
    logic [1:0]       op_sel = '0;
    logic             is_double = 1'b0;
    logic [2:0]       rm_field = '0;
    logic [REG_W-1:0] opnd_a = '0;
    logic [REG_W-1:0] opnd_b = '0;
    logic             frm_we = 1'b0;
    logic [2:0]       frm_wdata = '0;
    logic             exc_valid = 1'b0;
    logic [4:0]       exc_flags = '0;
    logic             res_valid;
    logic [REG_W-1:0] res_data;
    logic [2:0]       res_rm;
    logic             res_illegal;
    logic [4:0]       fflags;
    logic             fs_dirty;

    always #5 clk = ~clk;

    fsgn_flag_unit #(.REG_W(REG_W)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .is_double(is_double), .rm_field(rm_field), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .frm_we(frm_we), .frm_wdata(frm_wdata),
        .exc_valid(exc_valid), .exc_flags(exc_flags), .res_valid(res_valid),
        .res_data(res_data), .res_rm(res_rm), .res_illegal(res_illegal),
        .fflags(fflags), .fs_dirty(fs_dirty)
    );

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [2:0]       rm;
        logic             ill;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    logic [2:0] frm_m = 3'd0;
    bit    finished = 0;

    function automatic logic [REG_W-1:0] box_sp(logic [31:0] v);
        return {{(REG_W-32){1'b1}}, v};
    endfunction

    function automatic logic [REG_W-1:0] box_dp(logic [63:0] v);
        return {{(REG_W-64){1'b1}}, v};
    endfunction

    function automatic logic new_sign(logic [1:0] op, logic sa, logic sb);
        if (op == 2'd0) return sb;
        if (op == 2'd1) return ~sb;
        return sa ^ sb;
    endfunction

    function automatic exp_t predict(logic [1:0] op, logic dbl, logic [2:0] rm,
                                     logic [REG_W-1:0] a, logic [REG_W-1:0] b,
                                     logic [2:0] frm);
        exp_t e;
        logic [63:0] xd, yd;
        logic [31:0] xs, ys;
        e.rm   = (rm == 3'd7) ? frm : rm;
        e.ill  = (e.rm > 3'd4) || (op == 2'd3);
        e.data = '0;
        if (!e.ill) begin
            if (dbl) begin
                xd = (&a[REG_W-1:64]) ? a[63:0] : 64'h7FF8_0000_0000_0000;
                yd = (&b[REG_W-1:64]) ? b[63:0] : 64'h7FF8_0000_0000_0000;
                e.data = box_dp({new_sign(op, xd[63], yd[63]), xd[62:0]});
            end else begin
                xs = (&a[REG_W-1:32]) ? a[31:0] : 32'h7FC0_0000;
                ys = (&b[REG_W-1:32]) ? b[31:0] : 32'h7FC0_0000;
                e.data = box_sp({new_sign(op, xs[31], ys[31]), xs[30:0]});
            end
        end
        return e;
    endfunction

    task automatic check(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(string tag, logic [1:0] op, logic dbl, logic [2:0] rm,
                         logic [REG_W-1:0] a, logic [REG_W-1:0] b);
        sb_q.push_back(predict(op, dbl, rm, a, b, frm_m));
        tag_q.push_back(tag);
        op_valid  = 1'b1;
        op_sel    = op;
        is_double = dbl;
        rm_field  = rm;
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic write_frm(logic [2:0] v);
        frm_we    = 1'b1;
        frm_wdata = v;
        @(negedge clk);
        frm_we    = 1'b0;
        frm_m     = v;
    endtask

    task automatic send_exc(logic [4:0] f);
        exc_valid = 1'b1;
        exc_flags = f;
        @(negedge clk);
        exc_valid = 1'b0;
        exc_flags = '0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        check("scoreboard empty", REG_W'(sb_q.size()), '0);
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL unexpected result actual=%h expected=none", res_data);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check({t, " data"}, res_data, e.data);
                check({t, " rm"}, REG_W'(res_rm), REG_W'(e.rm));
                check({t, " illegal"}, REG_W'(res_illegal), REG_W'(e.ill));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 fflags", REG_W'(fflags), '0);
        check("R1 dirty", REG_W'(fs_dirty), '0);
        check("R1 res_valid", REG_W'(res_valid), '0);

        // R10 zero flags leave dirty alone
        send_exc(5'd0);
        check("R10 zero exc dirty", REG_W'(fs_dirty), '0);
        check("R9 zero exc fflags", REG_W'(fflags), '0);

        // R8 illegal op does not dirty
        do_op("R8 rm5", 2'd0, 1'b0, 3'd5, box_sp(32'h3F80_0000), box_sp(32'hC000_0000));
        check("R8 illegal no dirty", REG_W'(fs_dirty), '0);

        // R1 dynamic mode is 0 after reset; R11 legal op dirties
        do_op("R1 frm reset", 2'd0, 1'b0, 3'd7, box_sp(32'h3F80_0000), box_sp(32'hC000_0000));
        check("R11 op dirty", REG_W'(fs_dirty), 1);

        // R2 R3 R4 single
        do_op("R2 sp copy", 2'd0, 1'b0, 3'd0, box_sp(32'hC049_0FDB), box_sp(32'h0000_0001));
        do_op("R3 sp neg", 2'd1, 1'b0, 3'd1, box_sp(32'h4049_0FDB), box_sp(32'h4000_0000));
        do_op("R4 sp xor", 2'd2, 1'b0, 3'd2, box_sp(32'hBF80_0000), box_sp(32'hBF80_0000));
        do_op("R4 sp xor2", 2'd2, 1'b0, 3'd3, box_sp(32'hBF80_0000), box_sp(32'h3F80_0000));
        // R2 R3 R4 double
        do_op("R2 dp copy", 2'd0, 1'b1, 3'd4, box_dp(64'h4009_21FB_5444_2D18), box_dp(64'h8000_0000_0000_0000));
        do_op("R3 dp neg", 2'd1, 1'b1, 3'd0, box_dp(64'hC009_21FB_5444_2D18), box_dp(64'hC000_0000_0000_0000));
        do_op("R4 dp xor", 2'd2, 1'b1, 3'd0, box_dp(64'hC009_21FB_5444_2D18), box_dp(64'h3FF0_0000_0000_0000));

        // R5 single boxing
        do_op("R5 bad a", 2'd0, 1'b0, 3'd0, {96'h0, 32'h3F80_0000}, box_sp(32'h8000_0000));
        do_op("R5 bad b", 2'd1, 1'b0, 3'd0, box_sp(32'hBF80_0000), {64'h0, 64'hFFFF_FFFF_8000_0000});
        do_op("R5 dbl in sp", 2'd0, 1'b0, 3'd0, box_dp(64'h1234_5678_3F80_0000), box_sp(32'h3F80_0000));
        // R6 double boxing
        do_op("R6 bad a", 2'd1, 1'b1, 3'd0, {64'h0, 64'h3FF0_0000_0000_0000}, box_dp(64'h0));
        do_op("R6 bad b", 2'd0, 1'b1, 3'd0, box_dp(64'hBFF0_0000_0000_0000), {64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});

        // R7 static fields pass through
        for (int m = 0; m < 5; m++) begin
            do_op("R7 static", 2'd0, 1'b0, 3'(m), box_sp(32'h4000_0000), box_sp(32'h0));
        end
        write_frm(3'd3);
        do_op("R7 dynamic", 2'd2, 1'b1, 3'd7, box_dp(64'h1), box_dp(64'h2));
        // R7 write in same cycle: op sees old mode 3
        frm_we    = 1'b1;
        frm_wdata = 3'd1;
        do_op("R7 same cycle", 2'd0, 1'b0, 3'd7, box_sp(32'h1), box_sp(32'h2));
        frm_we    = 1'b0;
        frm_m     = 3'd1;
        do_op("R7 after write", 2'd0, 1'b0, 3'd7, box_sp(32'h1), box_sp(32'h2));
        // R8 illegal cases
        write_frm(3'd6);
        do_op("R8 dyn bad", 2'd0, 1'b0, 3'd7, box_sp(32'h1), box_sp(32'h2));
        do_op("R8 rm6", 2'd1, 1'b1, 3'd6, box_dp(64'h1), box_dp(64'h2));
        do_op("R8 op3", 2'd3, 1'b0, 3'd0, box_sp(32'h1), box_sp(32'h2));
        drain();

        // R9 accrual, bit0 NX, bit4 NV, bit1 UF, bit3 DZ
        send_exc(5'b00001);
        check("R9 NX", REG_W'(fflags), 5'b00001);
        send_exc(5'b10000);
        check("R9 NV", REG_W'(fflags), 5'b10001);
        send_exc(5'b00000);
        check("R9 zero keeps", REG_W'(fflags), 5'b10001);
        send_exc(5'b01010);
        check("R9 UF DZ", REG_W'(fflags), 5'b11011);

        // second reset, then R10 nonzero exc dirties
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        frm_m = 3'd0;
        check("R1 fflags again", REG_W'(fflags), '0);
        check("R1 dirty again", REG_W'(fs_dirty), '0);
        send_exc(5'b00100);
        check("R10 exc dirty", REG_W'(fs_dirty), 1);
        check("R9 OF", REG_W'(fflags), 5'b00100);
        do_op("R1 frm cleared", 2'd0, 1'b0, 3'd7, box_sp(32'h5), box_sp(32'h8000_0000));
        drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule